// File: doc/BRIEF.md
# Layer Pipeline Dependency Scheduler

This block decides when each layer stage of a feed-forward network may begin work on each input sample. The network of `NUM_LAYERS` layers is modelled as a chain of `NUM_LAYERS+2` stages (an input transfer stage, one stage per layer, an output transfer stage). Stage 0 is the entry stage and stage `NUM_LAYERS+1` is the last. Every pair of neighbouring stages shares a single intermediate buffer. A task is the pair (sample i, stage j). It may start only when two things are true. Stage j-1 must have finished sample i, so its data is ready. Stage j+1 must have finished sample i-1, so the one shared buffer between j and j+1 has been drained.

The scheduler receives a one-cycle completion pulse from each stage datapath and issues a one-cycle start pulse to each stage, tagged with the sample index. Samples enter through a valid/ready handshake, and an accepted sample starts stage 0 in the same cycle. Stages are eligible independently, so successive samples overlap along diagonal wavefronts: task (i,j) runs alongside (i+1,j-2). In steady state the spacing between samples settles to the largest sum of two adjacent stage latencies. Per stage, the block stores only a busy flag, a count of issued samples and a count of finished samples. It keeps no table of events.

Top module: `layer_wave_sched`

## Requirements
- R1: Reset is synchronous and active low. After reset every stage is idle with both of its counts at zero. While `in_valid_i` is low, no start pulse is issued and `in_ready_o` is high, so sample 0 is gated only by the chain rule.
- R2: A start pulse on `start_o[j]` carries the sample index on bits `[8*j+7:8*j]` of `start_idx_o`. Each stage issues samples strictly in the order 0, 1, 2, and so on.
- R3: Stage j>0 starts sample i only after it has seen the completion pulse of stage j-1 for sample i.
- R4: Stage j below the last starts sample i>0 only after stage j+1 has pulsed completion for sample i-1. The last stage has no buffer condition.
- R5: A stage holds at most one sample from its start pulse until its `done_i[j]` pulse. A stage starts in the first cycle in which all of its conditions hold: the cycle after the enabling completion pulse, or the acceptance cycle for stage 0.
- R6: Several stages that become eligible in the same cycle all receive start pulses in that cycle.
- R7: `in_ready_o` is high exactly when stage 0 is idle and its buffer condition holds. `start_o[0]` equals `in_valid_i && in_ready_o`.
- R8: Sample indices are 8 bits wide and wrap from 255 to 0 with no effect on ordering or dependency checks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid_i | input | 1 | A new sample is offered |
| in_ready_o | output | 1 | Stage 0 can take a sample this cycle |
| done_i | input | NUM_LAYERS+2 | One-cycle completion pulse per stage (only while that stage is busy) |
| start_o | output | NUM_LAYERS+2 | One-cycle start pulse per stage |
| start_idx_o | output | 8*(NUM_LAYERS+2) | Sample index per stage, lane j at bits 8*j upward |

## Verification
The condition that is hardest to reach from the ports is the buffer rule actually holding a stage back. This requires a downstream stage that is still busy with the previous sample while the upstream stage already has fresh data. The stimulus reaches it with a phase in which one middle layer is much slower than its neighbours, and with a phase of random latencies and gaps in the offered samples. More than 256 samples are sent in total, so every stage's index passes through the wrap while the wavefront overlap is active.

// File: rtl/lws_pkg.sv
// Shared types for the layer wavefront scheduler.
// Assumes at most one sample is outstanding per stage, so an 8-bit
// modular index is enough to order neighbouring stages.
package lws_pkg;
    localparam int IDX_W = 8;
    typedef logic [IDX_W-1:0] sidx_t;
endpackage

// File: rtl/lws_stage_track.sv
// Per-stage bookkeeping: busy flag, count of samples issued (equal to the
// index of the next sample) and count of samples finished (one past the
// index of the last finished sample). Assumes start and done never
// coincide for one stage and that done arrives only while busy.
module lws_stage_track
    import lws_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start_i,
    input  logic  done_i,
    output logic  busy_o,
    output sidx_t next_o,
    output sidx_t fin_o
);
    // Track occupancy and both modular counts of this stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            next_o <= '0;
            fin_o  <= '0;
        end else if (start_i) begin
            busy_o <= 1'b1;
            next_o <= next_o + 1'b1;
        end else if (done_i) begin
            busy_o <= 1'b0;
            fin_o  <= fin_o + 1'b1;
        end
    end
endmodule

// File: rtl/lws_dep_check.sv
// Eligibility of one stage. The chain rule compares the upstream finished
// count with this stage's next index (the difference is 0 or 1). The buffer
// rule needs the downstream finished count to equal the next index. The
// entry stage takes its chain condition from the external valid; the last
// stage has no downstream buffer.
module lws_dep_check
    import lws_pkg::*;
#(
    parameter bit HAS_UP = 1'b1,
    parameter bit HAS_DN = 1'b1
) (
    input  logic  busy_i,
    input  sidx_t next_i,
    input  sidx_t up_fin_i,
    input  sidx_t dn_fin_i,
    input  logic  ext_ok_i,
    output logic  free_o,
    output logic  fire_o
);
    logic chain_ok;
    logic buf_ok;

    // Combine the data-ready rule and the single-buffer rule.
    always_comb begin
        chain_ok = HAS_UP ? (up_fin_i != next_i) : ext_ok_i;
        buf_ok   = HAS_DN ? (dn_fin_i == next_i) : 1'b1;
        free_o   = !busy_i && buf_ok;
        fire_o   = free_o && chain_ok;
    end
endmodule

// File: rtl/layer_wave_sched.sv
// Layer wavefront scheduler top. One tracker and one dependency check per
// stage; all eligible stages start together in the same cycle. Start
// pulses are combinational from registered state and in_valid_i, so a
// stage starts the cycle after the completion that enables it.
module layer_wave_sched
    import lws_pkg::*;
#(
    parameter  int NUM_LAYERS = 3,
    localparam int NUM_STAGES = NUM_LAYERS + 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid_i,
    output logic                          in_ready_o,
    input  logic [NUM_STAGES-1:0]         done_i,
    output logic [NUM_STAGES-1:0]         start_o,
    output logic [NUM_STAGES*IDX_W-1:0]   start_idx_o
);
    logic  [NUM_STAGES-1:0] busy;
    logic  [NUM_STAGES-1:0] free;
    logic  [NUM_STAGES-1:0] fire;
    sidx_t                  nxt [NUM_STAGES];
    sidx_t                  fin [NUM_STAGES];

    for (genvar j = 0; j < NUM_STAGES; j++) begin : g_stage
        localparam int UPJ = (j == 0) ? 0 : j - 1;
        localparam int DNJ = (j == NUM_STAGES - 1) ? j : j + 1;

        lws_stage_track u_track (
            .clk     (clk),
            .rst_n   (rst_n),
            .start_i (fire[j]),
            .done_i  (done_i[j]),
            .busy_o  (busy[j]),
            .next_o  (nxt[j]),
            .fin_o   (fin[j])
        );

        lws_dep_check #(
            .HAS_UP (j != 0),
            .HAS_DN (j != NUM_STAGES - 1)
        ) u_dep (
            .busy_i   (busy[j]),
            .next_i   (nxt[j]),
            .up_fin_i (fin[UPJ]),
            .dn_fin_i (fin[DNJ]),
            .ext_ok_i ((j == 0) ? in_valid_i : 1'b0),
            .free_o   (free[j]),
            .fire_o   (fire[j])
        );

        // Present the tag of the sample being started on this lane.
        assign start_idx_o[j*IDX_W +: IDX_W] = nxt[j];
    end

    // Entry handshake and start pulses.
    assign in_ready_o = free[0];
    assign start_o    = fire;
endmodule

// File: rtl/layer_wave_sched_chk.sv
// Checker for the layer wavefront scheduler, bound to the top. Keeps its
// own modular start and completion counts per stage from the ports.
module layer_wave_sched_chk
    import lws_pkg::*;
#(
    parameter int NUM_STAGES = 5
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        in_valid_i,
    input logic                        in_ready_o,
    input logic [NUM_STAGES-1:0]       done_i,
    input logic [NUM_STAGES-1:0]       start_o,
    input logic [NUM_STAGES*IDX_W-1:0] start_idx_o
);
    sidx_t st_cnt [NUM_STAGES];
    sidx_t dn_cnt [NUM_STAGES];

    // Count start and completion pulses seen at the ports.
    always_ff @(posedge clk) begin
        for (int j = 0; j < NUM_STAGES; j++) begin
            if (!rst_n) begin
                st_cnt[j] <= '0;
                dn_cnt[j] <= '0;
            end else begin
                if (start_o[j]) st_cnt[j] <= st_cnt[j] + 1'b1;
                if (done_i[j])  dn_cnt[j] <= dn_cnt[j] + 1'b1;
            end
        end
    end

    assert_accept_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o) |-> start_o[0]);
    assert_start_needs_offer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_o[0] |-> (in_valid_i && in_ready_o));

    for (genvar j = 0; j < NUM_STAGES; j++) begin : g_chk
        assert_tag_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
            start_o[j] |-> (start_idx_o[j*IDX_W +: IDX_W] == st_cnt[j]));
        assert_no_back_to_back_R5: assert property (@(posedge clk) disable iff (!rst_n)
            start_o[j] |=> !start_o[j]);
        if (j > 0) begin : g_up
            assert_chain_rule_R3: assert property (@(posedge clk) disable iff (!rst_n)
                start_o[j] |-> (dn_cnt[j-1] == sidx_t'(st_cnt[j] + 1'b1)));
        end
        if (j < NUM_STAGES - 1) begin : g_dn
            assert_buffer_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
                start_o[j] |-> (dn_cnt[j+1] == st_cnt[j]));
        end
    end
endmodule

bind layer_wave_sched layer_wave_sched_chk #(.NUM_STAGES(NUM_STAGES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .done_i      (done_i),
    .start_o     (start_o),
    .start_idx_o (start_idx_o)
);

// File: tb/test_layer_wave_sched.sv
module test_layer_wave_sched;
    localparam int NL = 3;
    localparam int NS = NL + 2;
    localparam int IW = 8;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            in_valid;
    logic            in_ready;
    logic [NS-1:0]   done;
    logic [NS-1:0]   start;
    logic [NS*IW-1:0] sidx;

    always #10 clk = ~clk;

    layer_wave_sched #(.NUM_LAYERS(NL)) i_layer_wave_sched (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (in_valid),
        .in_ready_o  (in_ready),
        .done_i      (done),
        .start_o     (start),
        .start_idx_o (sidx)
    );

    int checks = 0;
    int fails  = 0;
    int m_started [NS];
    int m_done    [NS];
    bit m_busy    [NS];
    int rem       [NS];
    int sent = 0;
    int target = 0;
    int mode = 0;
    bit seen_multi = 0;
    bit seen_bp = 0;
    bit seen_wrap = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int lat(input int j);
        if (mode == 0) return 1;
        if (mode == 1) return $urandom_range(5, 1);
        return (j == 2) ? 12 : 1;
    endfunction

    // One cycle: drive at the falling edge, compare, advance the model.
    task automatic step();
        bit e [NS];
        bit ch [NS];
        bit bf [NS];
        bit exp_ready;
        int nstart;
        @(negedge clk);
        for (int j = 0; j < NS; j++) begin
            done[j] = 1'b0;
            if (rem[j] > 0) begin
                rem[j]--;
                if (rem[j] == 0) done[j] = 1'b1;
            end
        end
        in_valid = (sent < target) && ((mode != 1) || ($urandom_range(3, 0) != 0));
        #1;
        exp_ready = 1'b0;
        for (int j = 0; j < NS; j++) begin
            ch[j] = (j == 0) ? in_valid : (m_done[j-1] > m_started[j]);
            bf[j] = (j == NS - 1) || (m_done[j+1] == m_started[j]);
            e[j]  = !m_busy[j] && bf[j] && ch[j];
            if (j == 0) exp_ready = !m_busy[0] && bf[0];
        end
        check(in_ready == exp_ready, "R7", "in_ready", in_ready, exp_ready);
        if (in_valid && !in_ready) seen_bp = 1'b1;
        nstart = 0;
        for (int j = 0; j < NS; j++) begin
            string rq;
            if (j == 0)          rq = "R7";
            else if (!start[j])  rq = "R5";
            else if (m_busy[j])  rq = "R5";
            else if (!ch[j])     rq = "R3";
            else                 rq = "R4";
            check(start[j] == e[j], rq, $sformatf("start stage %0d", j), start[j], e[j]);
            if (start[j]) nstart++;
            if (start[j] && e[j]) begin
                int exi = m_started[j] % 256;
                int act = int'(sidx[j*IW +: IW]);
                check(act == exi, (m_started[j] >= 256) ? "R8" : "R2",
                      $sformatf("index stage %0d", j), act, exi);
                if (j == NS - 1 && m_started[j] >= 256 && act == 0) seen_wrap = 1'b1;
            end
        end
        if (nstart >= 2) seen_multi = 1'b1;
        for (int j = 0; j < NS; j++) begin
            if (done[j]) begin
                m_done[j]++;
                m_busy[j] = 1'b0;
            end
            if (e[j]) begin
                m_busy[j] = 1'b1;
                m_started[j]++;
                rem[j] = lat(j);
                if (j == 0) sent++;
            end
        end
    endtask

    task automatic run_phase(input int md, input int n);
        mode = md;
        target = sent + n;
        while (m_done[NS-1] < target) step();
    endtask

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b0;
        done = '0;
        for (int j = 0; j < NS; j++) begin
            m_started[j] = 0; m_done[j] = 0; m_busy[j] = 1'b0; rem[j] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: idle after reset, ready for sample 0, nothing started.
        check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        check(start == '0, "R1", "start after reset", int'(start), 0);
        step();
        check(start == '0, "R1", "start with no offer", int'(start), 0);
        run_phase(0, 100);   // unit latencies: dense wavefront
        run_phase(1, 120);   // random latencies and offer gaps
        run_phase(2, 60);    // slow middle layer: buffer rule blocks upstream
        check(seen_multi, "R6", "same-cycle multi-start seen", seen_multi, 1);
        check(seen_bp, "R4", "upstream held by busy buffer seen", seen_bp, 1);
        check(seen_wrap, "R8", "last stage index wrapped to 0", seen_wrap, 1);
        check(m_started[0] == 280, "R2", "samples accepted", m_started[0], 280);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule